// File: doc/BRIEF.md
# Fully Associative Shadow Translation Cache

This block is a small translation cache placed in front of a larger unified TLB, serving a single access stream (instruction fetch or data access). Each lookup presents a virtual page number, the current address-space identifier and whether the access is a store. On a hit, the physical page number and any permission fault come back combinationally in the same cycle.

On a miss, the block stalls the requestor and raises a refill request toward the unified TLB until a reply arrives. A successful reply is installed into the cache and forwarded to the requestor. A fault reply is forwarded but not installed. Only hardware ever writes the entries, and they track the most recently used translations.

A fence input invalidates entries. It can be filtered by page, by address space, by both, or by neither. A fence that overlaps an outstanding refill causes that refill to be thrown away when it returns, so a stale translation never lands in the cache.

Top module: `shadow_tlb`

## Requirements
- R1: After reset every entry is invalid: `miss_req` and `lk_done` are 0 and the first lookup of any page misses.
- R2: A lookup hits only when both the ASID and the VPN of a valid entry match. A hit drives `lk_done`=1 and `lk_ppn` in the same cycle as `lk_valid`.
- R3: A miss drives `lk_done`=0 in the lookup cycle. From the next cycle, `miss_req`=1 with `miss_vpn`/`miss_asid` equal to the missed page, and it stays high, with `lk_done`=0, until `fill_valid`.
- R4: A non-fault reply (`fill_valid`=1, `fill_fault`=0) drives `lk_done`=1 with `lk_ppn`=`fill_ppn` in the reply cycle and installs the translation, so a later lookup of that page hits with that PPN.
- R5: A fault reply (`fill_fault`=1) drives `lk_done`=1 and `lk_fault`=1 in the reply cycle and installs nothing; a later lookup of the same page misses.
- R6: Any access to a page whose accessed bit is 0 returns `lk_fault`=1, both on a hit and on an installing reply.
- R7: A store (`lk_store`=1) to a page whose dirty bit is 0 returns `lk_fault`=1. A load with the accessed bit set and the dirty bit clear returns `lk_fault`=0.
- R8: A fill goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the least recently used entry, where both hits and fills count as uses.
- R9: A `fence` pulse invalidates every valid entry whose VPN equals `fence_vpn` (only when `fence_use_vpn`=1) and whose ASID equals `fence_asid` (only when `fence_use_asid`=1). With both filters at 0, it invalidates every entry.
- R10: A `fence` pulse during an outstanding miss, or in the reply cycle itself, makes the block drop the reply: `lk_done`=0, nothing is installed, and the still-held lookup starts a new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present; held until `lk_done` |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_store | input | 1 | 1 = store access, 0 = load/fetch |
| lk_done | output | 1 | Result valid this cycle |
| lk_ppn | output | PPN_W | Physical page number of the result |
| lk_fault | output | 1 | Page fault for this access |
| miss_req | output | 1 | Refill request to the unified TLB |
| miss_vpn | output | VPN_W | Page requested |
| miss_asid | output | ASID_W | ASID requested |
| fill_valid | input | 1 | Refill reply present |
| fill_fault | input | 1 | Reply is a fault, not a translation |
| fill_ppn | input | PPN_W | Reply physical page number |
| fill_a | input | 1 | Reply accessed bit |
| fill_d | input | 1 | Reply dirty bit |
| fence | input | 1 | Invalidation pulse |
| fence_use_vpn | input | 1 | Restrict fence to `fence_vpn` |
| fence_vpn | input | VPN_W | Page to invalidate |
| fence_use_asid | input | 1 | Restrict fence to `fence_asid` |
| fence_asid | input | ASID_W | ASID to invalidate |

## Verification
The hardest case to reach is a fence that races an outstanding refill. This includes a fence in the same cycle as the reply, where the dropped reply must not finish the access and the still-held lookup must start a second request. The stimulus reaches it by injecting a fence into the wait window on a small share of random misses, and by directed accesses that place the fence one cycle before the reply and exactly on it. A narrow pool of pages and ASIDs keeps the cache full, so the least-recently-used choice decides later hits and misses, and a reference model predicts each of them.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } stlb_state_e;

   // permission check shared by the hit path and the refill path
   function automatic logic perm_fault(input logic acc, input logic dirty, input logic store);
      return (!acc) || (store && !dirty);
   endfunction

endpackage

// File: rtl/stlb_entry_array.sv
module stlb_entry_array #(
   parameter int ENTRIES         = 8,
   parameter int VPN_W           = 20,
   parameter int PPN_W           = 22,
   parameter int ASID_W          = 9,
   parameter bit SELECTIVE_FENCE = 1'b1,
   localparam int IDX_W          = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [ASID_W-1:0]  lk_asid,
   output logic               hit,
   output logic [IDX_W-1:0]   hit_idx,
   output logic [PPN_W-1:0]   hit_ppn,
   output logic               hit_a,
   output logic               hit_d,
   output logic [ENTRIES-1:0] valid_vec,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  logic               wr_a,
   input  logic               wr_d,
   input  logic               fence,
   input  logic               fence_use_vpn,
   input  logic [VPN_W-1:0]   fence_vpn,
   input  logic               fence_use_asid,
   input  logic [ASID_W-1:0]  fence_asid
);

   logic [ENTRIES-1:0] v_q;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [ENTRIES-1:0] a_q;
   logic [ENTRIES-1:0] d_q;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] kill_vec;

   // per-entry comparators and fence selectors
   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign hit_vec[g] = v_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
      if (SELECTIVE_FENCE) begin : g_sel
         assign kill_vec[g] = (!fence_use_vpn  || (vpn_q[g]  == fence_vpn)) &&
                              (!fence_use_asid || (asid_q[g] == fence_asid));
      end else begin : g_all
         assign kill_vec[g] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
               v_q[i] <= 1'b1;
            end else if (fence && kill_vec[i]) begin
               v_q[i] <= 1'b0;
            end
         end
      end
   end

   // payload has no reset: only read behind a valid bit
   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (wr_en && (wr_idx == IDX_W'(i))) begin
            vpn_q[i]  <= lk_vpn;
            asid_q[i] <= lk_asid;
            ppn_q[i]  <= wr_ppn;
            a_q[i]    <= wr_a;
            d_q[i]    <= wr_d;
         end
      end
   end

   // one-hot read mux
   always_comb begin
      hit_idx = '0;
      hit_ppn = '0;
      hit_a   = 1'b0;
      hit_d   = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            hit_idx = hit_idx | IDX_W'(i);
            hit_ppn = hit_ppn | ppn_q[i];
            hit_a   = hit_a | a_q[i];
            hit_d   = hit_d | d_q[i];
         end
      end
   end

   assign hit       = |hit_vec;
   assign valid_vec = v_q;

   AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));  // R2
   AST_FENCE_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (fence && !fence_use_vpn && !fence_use_asid && !wr_en) |=> (valid_vec == '0));  // R9

endmodule

// File: rtl/stlb_lru.sv
module stlb_lru #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch_en,
   input  logic [IDX_W-1:0]   touch_idx,
   input  logic [ENTRIES-1:0] valid_vec,
   output logic [IDX_W-1:0]   victim_idx
);

   // age 0 = most recent; ages always form a permutation
   logic [IDX_W-1:0]   age_q [ENTRIES];
   logic [ENTRIES-1:0] oldest_vec;
   logic [IDX_W-1:0]   touch_age;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_old
      assign oldest_vec[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
   end

   assign touch_age = age_q[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (touch_idx == IDX_W'(i))   age_q[i] <= '0;
            else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   // lowest invalid slot first, otherwise the oldest one
   always_comb begin
      logic found;
      found      = 1'b0;
      victim_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!valid_vec[i] && !found) begin
            victim_idx = IDX_W'(i);
            found      = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (oldest_vec[i]) victim_idx = IDX_W'(i);
         end
      end
   end

   AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);  // R8
   AST_TOUCH_BECOMES_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (age_q[$past(touch_idx)] == '0));  // R8

endmodule

// File: rtl/stlb_ctrl.sv
module stlb_ctrl
   import stlb_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_store,
   input  logic              hit,
   input  logic              hit_a,
   input  logic              hit_d,
   input  logic              fence,
   input  logic              fill_valid,
   input  logic              fill_fault,
   input  logic              fill_a,
   input  logic              fill_d,
   output logic              lk_done,
   output logic              lk_fault,
   output logic              use_fill,
   output logic              miss_req,
   output logic [VPN_W-1:0]  miss_vpn,
   output logic [ASID_W-1:0] miss_asid,
   output logic              wr_en,
   output logic              touch_en,
   output logic              touch_sel_fill
);

   stlb_state_e       state_q, state_d;
   logic              drop_q;
   logic              store_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [ASID_W-1:0] asid_q;
   logic              kill;

   assign kill = drop_q || fence;

   always_comb begin
      state_d        = state_q;
      lk_done        = 1'b0;
      lk_fault       = 1'b0;
      use_fill       = 1'b0;
      miss_req       = 1'b0;
      wr_en          = 1'b0;
      touch_en       = 1'b0;
      touch_sel_fill = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (lk_valid) begin
               if (hit) begin
                  lk_done  = 1'b1;
                  lk_fault = perm_fault(hit_a, hit_d, lk_store);
                  touch_en = 1'b1;
               end else begin
                  state_d = ST_WAIT;
               end
            end
         end
         ST_WAIT: begin
            miss_req = 1'b1;
            use_fill = 1'b1;
            if (fill_valid) begin
               state_d = ST_IDLE;
               if (!kill) begin
                  lk_done = 1'b1;
                  if (fill_fault) begin
                     lk_fault = 1'b1;
                  end else begin
                     lk_fault       = perm_fault(fill_a, fill_d, store_q);
                     wr_en          = 1'b1;
                     touch_en       = 1'b1;
                     touch_sel_fill = 1'b1;
                  end
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         drop_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         drop_q  <= (state_q == ST_WAIT) && (state_d == ST_WAIT) && (drop_q || fence);
      end
   end

   always_ff @(posedge clk) begin
      if ((state_q == ST_IDLE) && lk_valid && !hit) begin
         vpn_q   <= lk_vpn;
         asid_q  <= lk_asid;
         store_q <= lk_store;
      end
   end

   assign miss_vpn  = vpn_q;
   assign miss_asid = asid_q;

   AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && !fill_valid) |=> miss_req);  // R3
   AST_MISS_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && $past(miss_req)) |-> ($stable(miss_vpn) && $stable(miss_asid)));  // R3
   AST_FAULT_NOT_INSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && fill_fault) |-> !wr_en);  // R5
   AST_FENCE_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && fence) |-> !wr_en);  // R10
   AST_DROPPED_REISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && fill_valid && fence && lk_valid) |-> !lk_done);  // R10

endmodule

// File: rtl/shadow_tlb.sv
module shadow_tlb #(
   parameter int ENTRIES         = 8,
   parameter int VPN_W           = 20,
   parameter int PPN_W           = 22,
   parameter int ASID_W          = 9,
   parameter bit SELECTIVE_FENCE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_store,
   output logic              lk_done,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic              lk_fault,
   output logic              miss_req,
   output logic [VPN_W-1:0]  miss_vpn,
   output logic [ASID_W-1:0] miss_asid,
   input  logic              fill_valid,
   input  logic              fill_fault,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic              fill_a,
   input  logic              fill_d,
   input  logic              fence,
   input  logic              fence_use_vpn,
   input  logic [VPN_W-1:0]  fence_vpn,
   input  logic              fence_use_asid,
   input  logic [ASID_W-1:0] fence_asid
);

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_chk_min
      $error("shadow_tlb: ENTRIES must be at least 2");
   end
   if ((ENTRIES & (ENTRIES - 1)) != 0) begin : g_chk_pow2
      $error("shadow_tlb: ENTRIES must be a power of two");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASID_W < 1) begin : g_chk_w
      $error("shadow_tlb: field widths must be positive");
   end

   logic               hit, hit_a, hit_d;
   logic [IDX_W-1:0]   hit_idx, victim_idx, touch_idx;
   logic [PPN_W-1:0]   hit_ppn;
   logic [ENTRIES-1:0] valid_vec;
   logic               wr_en, touch_en, touch_sel_fill, use_fill;

   assign touch_idx = touch_sel_fill ? victim_idx : hit_idx;
   assign lk_ppn    = use_fill ? fill_ppn : hit_ppn;

   stlb_entry_array #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
      .SELECTIVE_FENCE(SELECTIVE_FENCE)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn), .hit_a(hit_a), .hit_d(hit_d),
      .valid_vec(valid_vec),
      .wr_en(wr_en), .wr_idx(victim_idx), .wr_ppn(fill_ppn), .wr_a(fill_a), .wr_d(fill_d),
      .fence(fence), .fence_use_vpn(fence_use_vpn), .fence_vpn(fence_vpn),
      .fence_use_asid(fence_use_asid), .fence_asid(fence_asid)
   );

   stlb_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .touch_en(touch_en), .touch_idx(touch_idx),
      .valid_vec(valid_vec), .victim_idx(victim_idx)
   );

   stlb_ctrl #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_store(lk_store),
      .hit(hit), .hit_a(hit_a), .hit_d(hit_d),
      .fence(fence),
      .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_a(fill_a), .fill_d(fill_d),
      .lk_done(lk_done), .lk_fault(lk_fault), .use_fill(use_fill),
      .miss_req(miss_req), .miss_vpn(miss_vpn), .miss_asid(miss_asid),
      .wr_en(wr_en), .touch_en(touch_en), .touch_sel_fill(touch_sel_fill)
   );

   AST_MISS_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && !fill_valid) |-> !lk_done);  // R3
   AST_INSTALL_FILLS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !fence) |=> valid_vec[$past(victim_idx)]);  // R4
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!miss_req && (valid_vec == '0)));  // R1

endmodule

// File: tb/sim_shadow_tlb.sv
`timescale 1ns/1ps
module sim_shadow_tlb;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 0, lk_store = 0;
   logic [19:0] lk_vpn = '0;
   logic [8:0]  lk_asid = '0;
   logic        lk_done, lk_fault, miss_req;
   logic [21:0] lk_ppn;
   logic [19:0] miss_vpn;
   logic [8:0]  miss_asid;
   logic        fill_valid = 0, fill_fault = 0, fill_a = 0, fill_d = 0;
   logic [21:0] fill_ppn = '0;
   logic        fence = 0, fence_use_vpn = 0, fence_use_asid = 0;
   logic [19:0] fence_vpn = '0;
   logic [8:0]  fence_asid = '0;

   always #2.5 clk = ~clk;

   shadow_tlb u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_store(lk_store),
      .lk_done(lk_done), .lk_ppn(lk_ppn), .lk_fault(lk_fault),
      .miss_req(miss_req), .miss_vpn(miss_vpn), .miss_asid(miss_asid),
      .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_ppn(fill_ppn),
      .fill_a(fill_a), .fill_d(fill_d),
      .fence(fence), .fence_use_vpn(fence_use_vpn), .fence_vpn(fence_vpn),
      .fence_use_asid(fence_use_asid), .fence_asid(fence_asid)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   // reference model
   bit          m_v   [N];
   logic [19:0] m_vpn [N];
   logic [8:0]  m_asid[N];
   logic [21:0] m_ppn [N];
   bit          m_a   [N];
   bit          m_d   [N];
   int          m_age [N];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [21:0] ppn_of(input logic [19:0] v, input logic [8:0] s);
      return {v, 2'b01} ^ {s, 13'h0A5};
   endfunction

   function automatic int m_find(input logic [19:0] v, input logic [8:0] s);
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_asid[i] == s) return i;
      return -1;
   endfunction

   task automatic m_touch(input int k);
      int r;
      r = m_age[k];
      for (int i = 0; i < N; i++) begin
         if (i == k) m_age[i] = 0;
         else if (m_age[i] < r) m_age[i]++;
      end
   endtask

   function automatic int m_victim();
      for (int i = 0; i < N; i++) if (!m_v[i]) return i;
      for (int i = 0; i < N; i++) if (m_age[i] == N - 1) return i;
      return 0;
   endfunction

   task automatic m_fence(input bit uv, input logic [19:0] fv, input bit ua, input logic [8:0] fa);
      for (int i = 0; i < N; i++)
         if ((!uv || m_vpn[i] == fv) && (!ua || m_asid[i] == fa)) m_v[i] = 0;
   endtask

   task automatic m_reset();
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_age[i] = i; end
   endtask

   // mode: 0 normal reply, 1 fence while waiting, 2 fence on the reply, 3 fault reply
   task automatic do_access(input logic [19:0] v, input logic [8:0] s, input bit st,
                            input int mode, input bit ra, input bit rd);
      int k;
      int tries;
      bit ef;
      tries = 0;
      @(negedge clk);
      lk_valid = 1; lk_vpn = v; lk_asid = s; lk_store = st;
      forever begin
         #1;
         k = m_find(v, s);
         if (k >= 0) begin
            ef = !m_a[k] || (st && !m_d[k]);
            chk("R2 hit done", lk_done, 1);
            chk("R2 hit ppn", lk_ppn, m_ppn[k]);
            chk("R6 R7 hit fault", lk_fault, ef);
            m_touch(k);
            break;
         end
         chk("R3 miss cycle done", lk_done, 0);
         @(negedge clk); #1;
         chk("R3 miss_req", miss_req, 1);
         chk("R3 miss_vpn", miss_vpn, v);
         chk("R3 miss_asid", miss_asid, s);
         repeat ($urandom_range(0, 2)) begin
            @(negedge clk); #1;
            chk("R3 held", {miss_req, lk_done}, 2'b10);
         end
         if (mode == 1 && tries == 0) begin
            @(negedge clk);
            fence = 1; fence_use_vpn = 0; fence_use_asid = 0;
            m_fence(0, '0, 0, '0);
            @(negedge clk);
            fence = 0; fill_valid = 1; fill_fault = 0; fill_ppn = ppn_of(v, s); fill_a = 1; fill_d = 1;
            #1; chk("R10 dropped after fence", lk_done, 0);
            @(negedge clk); fill_valid = 0;
            tries++;
            continue;
         end
         if (mode == 2 && tries == 0) begin
            @(negedge clk);
            fence = 1; fence_use_vpn = 0; fence_use_asid = 0;
            fill_valid = 1; fill_fault = 0; fill_ppn = ppn_of(v, s); fill_a = 1; fill_d = 1;
            m_fence(0, '0, 0, '0);
            #1; chk("R10 dropped on reply", lk_done, 0);
            @(negedge clk); fence = 0; fill_valid = 0;
            tries++;
            continue;
         end
         @(negedge clk);
         fill_valid = 1; fill_fault = (mode == 3); fill_ppn = ppn_of(v, s); fill_a = ra; fill_d = rd;
         #1;
         chk("R4 R5 reply done", lk_done, 1);
         if (mode == 3) begin
            chk("R5 fault reply", lk_fault, 1);
         end else begin
            ef = !ra || (st && !rd);
            chk("R4 reply ppn", lk_ppn, ppn_of(v, s));
            chk("R6 R7 reply fault", lk_fault, ef);
            k = m_victim();
            m_v[k] = 1; m_vpn[k] = v; m_asid[k] = s; m_ppn[k] = ppn_of(v, s);
            m_a[k] = ra; m_d[k] = rd;
            m_touch(k);
         end
         break;
      end
      @(negedge clk);
      lk_valid = 0; fill_valid = 0; fill_fault = 0;
   endtask

   // sample a lookup result without letting a clock edge see it
   task automatic probe(input string tag, input logic [19:0] v, input logic [8:0] s, input bit exp_hit);
      @(negedge clk);
      lk_valid = 1; lk_vpn = v; lk_asid = s; lk_store = 0;
      #1;
      chk(tag, lk_done, exp_hit);
      chk({tag, " model"}, (m_find(v, s) >= 0), exp_hit);
      lk_valid = 0;
   endtask

   task automatic do_fence(input bit uv, input logic [19:0] fv, input bit ua, input logic [8:0] fa);
      @(negedge clk);
      fence = 1; fence_use_vpn = uv; fence_vpn = fv; fence_use_asid = ua; fence_asid = fa;
      @(negedge clk);
      fence = 0;
      m_fence(uv, fv, ua, fa);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      m_reset();
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      chk("R1 reset miss_req", miss_req, 0);
      chk("R1 reset done", lk_done, 0);
      probe("R1 first lookup misses", 20'h00123, 9'd1, 0);

      // R4 install and R2 ASID separation
      do_access(20'h00123, 9'd1, 0, 0, 1, 1);
      probe("R4 installed page hits", 20'h00123, 9'd1, 1);
      probe("R2 other ASID misses", 20'h00123, 9'd2, 0);
      probe("R2 other VPN misses", 20'h00124, 9'd1, 0);
      do_access(20'h00123, 9'd1, 1, 0, 1, 1);

      // R6 accessed bit clear
      do_access(20'h00200, 9'd1, 0, 0, 0, 1);
      do_access(20'h00200, 9'd1, 0, 0, 1, 1);
      // R7 dirty bit clear: load clean, store faults
      do_access(20'h00300, 9'd1, 0, 0, 1, 0);
      do_access(20'h00300, 9'd1, 1, 0, 1, 0);

      // R5 fault reply not installed
      do_access(20'h00400, 9'd3, 0, 3, 1, 1);
      probe("R5 fault not installed", 20'h00400, 9'd3, 0);

      // R8 replacement order
      do_fence(0, '0, 0, '0);
      probe("R9 full fence", 20'h00123, 9'd1, 0);
      for (int i = 0; i < N; i++) do_access(20'h00500 + 20'(i), 9'd1, 0, 0, 1, 1);
      do_access(20'h00500, 9'd1, 0, 0, 1, 1);
      do_access(20'h00600, 9'd1, 0, 0, 1, 1);
      probe("R8 LRU evicted", 20'h00501, 9'd1, 0);
      probe("R8 recently hit kept", 20'h00500, 9'd1, 1);

      // R9 selective fences
      do_access(20'h00777, 9'd2, 0, 0, 1, 1);
      do_fence(1, 20'h00502, 0, '0);
      probe("R9 vpn filter hits target", 20'h00502, 9'd1, 0);
      probe("R9 vpn filter spares others", 20'h00503, 9'd1, 1);
      do_fence(0, '0, 1, 9'd2);
      probe("R9 asid filter hits target", 20'h00777, 9'd2, 0);
      probe("R9 asid filter spares others", 20'h00504, 9'd1, 1);
      do_fence(1, 20'h00504, 1, 9'd2);
      probe("R9 both filters need both", 20'h00504, 9'd1, 1);
      do_fence(1, 20'h00504, 1, 9'd1);
      probe("R9 both filters match", 20'h00504, 9'd1, 0);

      // R10 fence racing a refill
      do_access(20'h00880, 9'd1, 0, 1, 1, 1);
      probe("R10 refetched page present", 20'h00880, 9'd1, 1);
      do_access(20'h00881, 9'd1, 1, 2, 1, 1);
      probe("R10 refetched page present", 20'h00881, 9'd1, 1);

      // random traffic on a narrow pool
      for (int n = 0; n < 600; n++) begin
         int r, md;
         r  = $urandom_range(0, 99);
         md = (r < 5) ? 1 : (r < 10) ? 2 : (r < 20) ? 3 : 0;
         if (n % 37 == 36)
            do_fence($urandom_range(0, 1), 20'h00A00 + 20'($urandom_range(0, 11)),
                     $urandom_range(0, 1), 9'($urandom_range(1, 3)));
         do_access(20'h00A00 + 20'($urandom_range(0, 11)), 9'($urandom_range(1, 3)),
                   $urandom_range(0, 1), md,
                   ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) < 7));
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule